// File: doc/BRIEF.md
# Secure Lock Sequencer

This block watches host register writes aimed at two registers of a watchdog card, the enable register and the trigger register. It recognises a fixed cross-register pattern: two enable-register writes that carry a key value, then one trigger-register write. When the pattern completes and the mode-select-A bit is set, the block flips a secure lock state. While the lock is held, the block asserts a keyboard-lock output and a reset-button-disable output. It also drives a status bit that software can read back. Running the same pattern again releases the lock.

The block has two state machines. The pattern detector has three states. SEQ_IDLE means no progress. SEQ_ONE means one keyed enable write has been seen. SEQ_TWO means two keyed enable writes have been seen. Its transitions are:
- first: SEQ_IDLE to SEQ_ONE on a keyed enable write.
- second: SEQ_ONE to SEQ_TWO on a keyed enable write.
- fire: SEQ_TWO to SEQ_IDLE on a lone trigger write. This pulses the completion signal.
- break: any state to SEQ_IDLE on a write that does not fit the pattern.
- hold: the state stays put in a cycle with no write strobe.

The lock machine has two states, LK_OPEN and LK_SHUT. It takes the transition toggle on a completion that has mode select A high. In every other case it takes the transition keep.

Top module: `secure_lock_seq`

## Requirements
- R1: A synchronous active-high reset puts the lock in LK_OPEN (all three outputs 0) and the detector in SEQ_IDLE, so partial progress made before reset is lost.
- R2: With mode_a at 1, two enable writes whose low 4 bits are 4'b0001 (upper data bits are ignored), followed by one trigger write, set the lock. The outputs show it from the cycle after the clock edge that samples the trigger write.
- R3: kbd_lock, btn_disable and secure_stat are all 1 while the lock is held and all 0 while it is open.
- R4: The same three-write pattern, completed while the lock is held and with mode_a at 1, releases the lock.
- R5: mode_a is sampled in the cycle of the completing trigger write. If it is 0 there, the lock is unchanged and the detector returns to SEQ_IDLE, even if mode_a was 1 during the enable writes.
- R6: Each of the following returns the detector to SEQ_IDLE without changing the lock: an enable write whose low nibble is not 4'b0001, a trigger write before two keyed enable writes, or a third enable write after two keyed ones.
- R7: A cycle in which both write strobes are high counts as a break. The lock is unchanged and the detector returns to SEQ_IDLE.
- R8: Cycles with neither strobe high change neither the detector nor the lock, so idle gaps between the writes of the pattern are allowed.
- R9: The lock state changes only at the edge that samples a trigger write. Enable writes alone never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | One-cycle strobe for a write to the enable register |
| trig_wr | input | 1 | One-cycle strobe for a write to the trigger register |
| wr_data | input | DATA_W | Write data; only the low KEY_W bits are compared with the key |
| mode_a | input | 1 | Mode-select-A bit that allows the lock to change |
| kbd_lock | output | 1 | Keyboard lock, high while the lock is held |
| btn_disable | output | 1 | Reset-button disable, high while the lock is held |
| secure_stat | output | 1 | Readable status bit that mirrors the lock |

## Verification
The pattern's completing trigger write and an enable write can land in the same cycle. In that case a fire and a break compete for the detector. The bench builds two keyed enable writes to reach SEQ_TWO and then raises both strobes together. It judges the outcome at the ports: the lock outputs must not change. A lone trigger write that follows must also leave the lock alone, which shows the detector fell back to SEQ_IDLE and did not stay armed. The same case is repeated with the lock held, to show that a release is blocked in the same way.

// File: rtl/slk_pkg.sv
package slk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_state_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_t;

endpackage

// File: rtl/slk_key_match.sv
module slk_key_match #(
    parameter int                DATA_W  = 8,
    parameter int                KEY_W   = 4,
    parameter logic [KEY_W-1:0]  KEY_VAL = 4'b0001
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o
);
    localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((64'd1 << KEY_W) - 64'd1);
    localparam logic [DATA_W-1:0] KEY_EXT  = DATA_W'(KEY_VAL);

    // Bits above the key field are masked off and do not matter.
    always_comb begin
        hit_o = ((data_i ^ KEY_EXT) & KEY_MASK) == '0;
    end
endmodule

// File: rtl/slk_seq_detect.sv
module slk_seq_detect
    import slk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic       trig_wr,
    input  logic       key_hit,
    output seq_state_t state_o,
    output logic       done_o
);
    seq_state_t state_q, state_d;
    logic       both_wr;
    logic       keyed_en;
    logic       lone_trig;

    always_comb begin
        both_wr   = en_wr & trig_wr;
        keyed_en  = en_wr & ~trig_wr & key_hit;
        lone_trig = trig_wr & ~en_wr;
    end

    // Next-state logic: first, second, fire, break, hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (keyed_en)                state_d = SEQ_ONE;   // first
                else                         state_d = SEQ_IDLE;
            end
            SEQ_ONE: begin
                if (both_wr)                 state_d = SEQ_IDLE;  // break
                else if (keyed_en)           state_d = SEQ_TWO;   // second
                else if (en_wr || trig_wr)   state_d = SEQ_IDLE;  // break
                else                         state_d = SEQ_ONE;   // hold
            end
            SEQ_TWO: begin
                if (both_wr)                 state_d = SEQ_IDLE;  // break
                else if (lone_trig)          state_d = SEQ_IDLE;  // fire
                else if (en_wr)              state_d = SEQ_IDLE;  // break
                else                         state_d = SEQ_TWO;   // hold
            end
            default:                         state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        done_o  = (state_q == SEQ_TWO) && lone_trig;
    end
endmodule

// File: rtl/slk_lock_state.sv
module slk_lock_state
    import slk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic mode_a,
    output logic kbd_lock,
    output logic btn_disable,
    output logic secure_stat
);
    lock_state_t lock_q, lock_d;
    logic        toggle;

    always_comb begin
        toggle = done_i & mode_a;
        lock_d = lock_q;
        unique case (lock_q)
            LK_OPEN: lock_d = toggle ? LK_SHUT : LK_OPEN;
            LK_SHUT: lock_d = toggle ? LK_OPEN : LK_SHUT;
            default: lock_d = LK_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) lock_q <= LK_OPEN;
        else     lock_q <= lock_d;
    end

    // Outputs
    always_comb begin
        kbd_lock    = (lock_q == LK_SHUT);
        btn_disable = (lock_q == LK_SHUT);
        secure_stat = (lock_q == LK_SHUT);
    end
endmodule

// File: rtl/secure_lock_seq.sv
module secure_lock_seq
    import slk_pkg::*;
#(
    parameter int               DATA_W  = 8,
    parameter int               KEY_W   = 4,
    parameter logic [KEY_W-1:0] KEY_VAL = 4'b0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_a,
    output logic              kbd_lock,
    output logic              btn_disable,
    output logic              secure_stat
);
    logic       key_hit;
    logic       seq_done;
    seq_state_t seq_st;

    slk_key_match #(
        .DATA_W  (DATA_W),
        .KEY_W   (KEY_W),
        .KEY_VAL (KEY_VAL)
    ) u_match (
        .data_i (wr_data),
        .hit_o  (key_hit)
    );

    slk_seq_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (en_wr),
        .trig_wr (trig_wr),
        .key_hit (key_hit),
        .state_o (seq_st),
        .done_o  (seq_done)
    );

    slk_lock_state u_lock (
        .clk         (clk),
        .rst         (rst),
        .done_i      (seq_done),
        .mode_a      (mode_a),
        .kbd_lock    (kbd_lock),
        .btn_disable (btn_disable),
        .secure_stat (secure_stat)
    );
endmodule

// File: rtl/secure_lock_chk.sv
module secure_lock_chk
    import slk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic       trig_wr,
    input  logic       mode_a,
    input  logic       kbd_lock,
    input  logic       btn_disable,
    input  logic       secure_stat,
    input  seq_state_t seq_st
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!secure_stat && seq_st == SEQ_IDLE));

    a_r2_enter: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SEQ_TWO && trig_wr && !en_wr && mode_a && !secure_stat) |=> secure_stat);

    a_r3_outputs_agree: assert property (@(posedge clk) disable iff (rst)
        (kbd_lock == secure_stat) && (btn_disable == secure_stat));

    a_r4_exit: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SEQ_TWO && trig_wr && !en_wr && mode_a && secure_stat) |=> !secure_stat);

    a_r5_mode_gate: assert property (@(posedge clk) disable iff (rst)
        !mode_a |=> $stable(secure_stat));

    a_r6_third_enable: assert property (@(posedge clk) disable iff (rst)
        (seq_st == SEQ_TWO && en_wr) |=> seq_st == SEQ_IDLE);

    a_r7_both_strobes: assert property (@(posedge clk) disable iff (rst)
        (en_wr && trig_wr) |=> ($stable(secure_stat) && seq_st == SEQ_IDLE));

    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_wr && !trig_wr) |=> ($stable(seq_st) && $stable(secure_stat)));

    a_r9_trigger_only: assert property (@(posedge clk) disable iff (rst)
        !trig_wr |=> $stable(secure_stat));
endmodule

bind secure_lock_seq secure_lock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_wr       (en_wr),
    .trig_wr     (trig_wr),
    .mode_a      (mode_a),
    .kbd_lock    (kbd_lock),
    .btn_disable (btn_disable),
    .secure_stat (secure_stat),
    .seq_st      (seq_st)
);

// File: tb/secure_lock_seq_test.sv
module secure_lock_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 1'b0;
    logic       trig_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mode_a = 1'b0;
    logic       kbd_lock, btn_disable, secure_stat;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    secure_lock_seq uut (
        .clk(clk), .rst(rst), .en_wr(en_wr), .trig_wr(trig_wr),
        .wr_data(wr_data), .mode_a(mode_a),
        .kbd_lock(kbd_lock), .btn_disable(btn_disable), .secure_stat(secure_stat)
    );

    // Checks all three outputs against the expected lock level (R3).
    task automatic check_lock(input string tag, input logic exp);
        checks++;
        if (kbd_lock !== exp || btn_disable !== exp || secure_stat !== exp) begin
            errors++;
            $display("FAIL %s: kbd=%b btn=%b stat=%b expected %b",
                     tag, kbd_lock, btn_disable, secure_stat, exp);
        end
    endtask

    // Drives are changed at the falling edge; each helper returns one falling edge
    // after its rising edge, so the outputs already show the result.
    task automatic en_write(input logic [7:0] d);
        @(negedge clk); en_wr = 1'b1; wr_data = d;
        @(negedge clk); en_wr = 1'b0; wr_data = 8'h00;
    endtask

    task automatic trig_write();
        @(negedge clk); trig_wr = 1'b1;
        @(negedge clk); trig_wr = 1'b0;
    endtask

    task automatic both_write(input logic [7:0] d);
        @(negedge clk); en_wr = 1'b1; trig_wr = 1'b1; wr_data = d;
        @(negedge clk); en_wr = 1'b0; trig_wr = 1'b0; wr_data = 8'h00;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        gap(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check_lock("R1 state after reset", 1'b0);
    endtask

    task automatic t_enter_exit();
        mode_a = 1'b1;
        en_write(8'h01); en_write(8'h01);
        check_lock("R9 enable writes alone", 1'b0);
        trig_write();
        check_lock("R2 enter lock", 1'b1);
        check_lock("R3 all outputs high when locked", 1'b1);
        en_write(8'hF1); en_write(8'hA1); trig_write();
        check_lock("R4 exit lock, upper bits ignored", 1'b0);
    endtask

    task automatic t_mode_gate();
        mode_a = 1'b0;
        en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R5 mode 0 blocks entry", 1'b0);
        // Mode bit sampled only at completion.
        en_write(8'h01); en_write(8'h01);
        @(negedge clk); mode_a = 1'b1;
        trig_write();
        check_lock("R5 mode sampled at trigger", 1'b1);
        en_write(8'h01); en_write(8'h01);
        @(negedge clk); mode_a = 1'b0;
        trig_write();
        check_lock("R5 mode 0 blocks exit", 1'b1);
        mode_a = 1'b1;
        trig_write();
        check_lock("R5 detector idle after gated fire", 1'b1);
        en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R4 release after gated attempt", 1'b0);
    endtask

    task automatic t_breaks();
        mode_a = 1'b1;
        en_write(8'h01); en_write(8'h03); trig_write();
        check_lock("R6 wrong nibble breaks", 1'b0);
        en_write(8'h01); trig_write(); en_write(8'h01); trig_write();
        check_lock("R6 early trigger breaks", 1'b0);
        en_write(8'h01); en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R6 third enable breaks", 1'b0);
        en_write(8'h01); en_write(8'h01); en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R6 restart after third enable", 1'b0);
    endtask

    task automatic t_gaps();
        mode_a = 1'b1;
        en_write(8'h01); gap(5); en_write(8'h01); gap(7);
        check_lock("R8 idle gaps keep lock", 1'b0);
        trig_write();
        check_lock("R8 pattern with gaps enters", 1'b1);
        gap(10);
        check_lock("R8 lock held over idle", 1'b1);
    endtask

    task automatic t_both_strobes();
        // Entered with lock held from t_gaps.
        mode_a = 1'b1;
        en_write(8'h01); en_write(8'h01); both_write(8'h01);
        check_lock("R7 both strobes block release", 1'b1);
        trig_write();
        check_lock("R7 detector idle after both strobes", 1'b1);
        en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R4 release after collision", 1'b0);
        en_write(8'h01); en_write(8'h01); both_write(8'h01);
        check_lock("R7 both strobes block entry", 1'b0);
        trig_write();
        check_lock("R7 no late fire", 1'b0);
    endtask

    task automatic t_reset_mid();
        mode_a = 1'b1;
        en_write(8'h01); en_write(8'h01); trig_write();
        check_lock("R2 lock before reset", 1'b1);
        do_reset();
        check_lock("R1 reset opens lock", 1'b0);
        en_write(8'h01); en_write(8'h01);
        do_reset();
        trig_write();
        check_lock("R1 reset drops partial progress", 1'b0);
    endtask

    initial begin
        gap(3);
        rst = 1'b0;
        gap(1);
        t_reset_state();
        t_enter_exit();
        t_mode_gate();
        t_breaks();
        t_gaps();
        t_both_strobes();
        t_reset_mid();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule